// File: doc/BRIEF.md
# Priority Request Error Recovery Controller

This block drives the active-low priority bus request of an agent. The priority request takes precedence over the arbitration among symmetric agents. In normal running the output is a registered copy of the request from local logic. When a bus reset, a bus initialization or an enabled address error is seen, the output is forced off. It then stays off for a quiet window whose length depends on the cause. During that window new local requests are ignored.

There is one exception. Local logic can report that it has issued the second or a later transaction of a locked sequence. An address error seen in that state does not give the normal window. Instead the request is reasserted after a short fixed gap, so that no other agent can cut into the locked sequence. The errors are detected elsewhere, and symmetric arbitration is handled elsewhere. This block only gates the request and times the recovery.

Top module: `prio_req_recovery`

## Requirements
- R1: While `rst_n` is sampled low, the output `pri_req_n` is high (inactive) after that clock edge, and the locked-progress flag is cleared.
- R2: With no recovery in progress, `pri_req_n` after each edge is the inverse of `local_req` sampled at that edge (one clock of latency).
- R3: When `bus_init_n` is sampled low, `pri_req_n` is high after that edge, and it stays high for as long as `bus_init_n` stays low.
- R4: Let edge t be the first edge at which `bus_init_n` is sampled high again. Then `pri_req_n` is high after edges t through t+3. From edge t+4 on it follows `local_req` as in R2.
- R5: When `addr_err_n` is sampled low while `addr_err_chk_en` is 1 and no bus-initialization recovery is running, `pri_req_n` is high after that edge (edge k).
- R6: Without the lock exception, `pri_req_n` stays high after edges k through k+3 and follows `local_req` from edge k+4. A further address error during the window restarts the window from its own edge.
- R7: When `addr_err_chk_en` is 0, `addr_err_n` has no effect on `pri_req_n`.
- R8: The locked-progress flag is set by a one-clock pulse on `lock_2nd_issued`. It is cleared by `lock_done`, by reset and by bus initialization. `lock_done` wins if both arrive in the same cycle.
- R9: If the locked-progress flag is set at the address-error edge k, `pri_req_n` is high after edges k and k+1 and low after edge k+2, whatever `local_req` is. After that it follows `local_req`.
- R10: Bus initialization takes precedence over an address error in the same cycle, and address errors are ignored during bus-initialization recovery. During any recovery, `local_req` has no effect on the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Bus reset, active low, synchronous |
| bus_init_n | input | 1 | Bus initialization condition, active low |
| addr_err_n | input | 1 | Address error condition, active low |
| addr_err_chk_en | input | 1 | 1 enables observation of address errors |
| local_req | input | 1 | Priority request from local logic, active high |
| lock_2nd_issued | input | 1 | Pulse: second transaction of a locked sequence issued |
| lock_done | input | 1 | Pulse: locked sequence finished |
| pri_req_n | output | 1 | Priority bus request, active low |

## Verification
Every result goes through the single output register. A deassertion therefore shows up one edge after the cause is sampled, and each recovery release shows up exactly at its nominated edge: t+4 after bus initialization ends, k+4 after an address error, or k+2 under the lock exception. Inputs change on the falling clock edge, and the output is read on the following falling edge, once per rising edge. This lets every expected value be tied to a single edge count from the stimulus. Each window is checked on its last quiet edge and on its first active edge, so a window that is one clock too long or too short is caught.

// File: rtl/prio_req_recovery.sv
module prio_req_recovery #(
  parameter int QUIET_CYC = 4,
  parameter int LOCK_GAP  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_init_n,
  input  logic addr_err_n,
  input  logic addr_err_chk_en,
  input  logic local_req,
  input  logic lock_2nd_issued,
  input  logic lock_done,
  output logic pri_req_n
);

  localparam int CW = (QUIET_CYC > 2) ? $clog2(QUIET_CYC) : 1;

  typedef enum logic [1:0] {ST_IDLE, ST_BHOLD, ST_BQUIET, ST_AQUIET} st_e;

  st_e           st;
  logic [CW-1:0] cnt;
  logic          pri_q, lock_q, force_q;
  logic          binit_hit, aerr_hit, in_binit;

  assign in_binit  = (st == ST_BHOLD) || (st == ST_BQUIET);
  assign binit_hit = ~bus_init_n;
  assign aerr_hit  = addr_err_chk_en & ~addr_err_n & ~in_binit;
  assign pri_req_n = ~pri_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      pri_q   <= 1'b0;
      lock_q  <= 1'b0;
      force_q <= 1'b0;
    end else begin
      if (binit_hit || lock_done) lock_q <= 1'b0;
      else if (lock_2nd_issued)   lock_q <= 1'b1;

      if (binit_hit) begin
        st    <= ST_BHOLD;
        pri_q <= 1'b0;
      end else if (aerr_hit) begin
        st      <= ST_AQUIET;
        pri_q   <= 1'b0;
        force_q <= lock_q;
        cnt     <= lock_q ? CW'(LOCK_GAP - 1) : CW'(QUIET_CYC - 1);
      end else begin
        case (st)
          ST_IDLE: pri_q <= local_req;
          ST_BHOLD: begin
            pri_q <= 1'b0;
            st    <= ST_BQUIET;
            cnt   <= CW'(QUIET_CYC - 1);
          end
          default: begin
            if (cnt == '0) begin
              st    <= ST_IDLE;
              pri_q <= local_req | ((st == ST_AQUIET) & force_q);
            end else begin
              cnt   <= cnt - 1'b1;
              pri_q <= 1'b0;
            end
          end
        endcase
      end
    end
  end

  a_r3_binit_off: assert property (@(posedge clk) disable iff (!rst_n)
    binit_hit |=> !pri_q);

  a_r5_aerr_off: assert property (@(posedge clk) disable iff (!rst_n)
    (aerr_hit && !binit_hit) |=> !pri_q);

  a_r4_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_IDLE) |-> !pri_q);

  a_r9_lock_reassert: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_AQUIET && force_q && cnt == '0 && !binit_hit && !aerr_hit) |=> pri_q);

  a_r7_follow_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && !binit_hit && !addr_err_chk_en) |=> (pri_q == $past(local_req)));

  a_r10_binit_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (binit_hit && !addr_err_n && addr_err_chk_en) |=> (st == ST_BHOLD));

endmodule

// File: tb/prio_req_recovery_tb.sv
`timescale 1ns/1ps
module prio_req_recovery_tb;
  logic clk = 1'b0;
  logic rst_n, bus_init_n, addr_err_n, addr_err_chk_en, local_req;
  logic lock_2nd_issued, lock_done;
  logic pri_req_n;
  int   n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  prio_req_recovery u_dut (
    .clk(clk), .rst_n(rst_n), .bus_init_n(bus_init_n), .addr_err_n(addr_err_n),
    .addr_err_chk_en(addr_err_chk_en), .local_req(local_req),
    .lock_2nd_issued(lock_2nd_issued), .lock_done(lock_done), .pri_req_n(pri_req_n)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic exp_active);
    n_chk++;
    if ((~pri_req_n) !== exp_active) begin
      n_fail++;
      $display("FAIL %s at %0t: request active=%0b expected=%0b", tag, $time, ~pri_req_n, exp_active);
    end
  endtask

  task automatic aerr_pulse();
    addr_err_n = 1'b0;
    tick();
    addr_err_n = 1'b1;
  endtask

  task automatic t_reset_follow();
    local_req = 1'b1;
    tick();
    chk("R1 reset holds off", 1'b0);
    rst_n = 1'b1;
    tick();
    chk("R2 follows req high", 1'b1);
    local_req = 1'b0;
    tick();
    chk("R2 follows req low", 1'b0);
    local_req = 1'b1;
    tick();
    chk("R2 follows req again", 1'b1);
  endtask

  task automatic t_binit();
    bus_init_n = 1'b0;
    tick();
    chk("R3 off after init seen", 1'b0);
    tick(); tick();
    chk("R3 off while init held", 1'b0);
    bus_init_n = 1'b1;
    tick();
    chk("R4 off at release edge t", 1'b0);
    tick(); tick(); tick();
    chk("R4 off at t+3", 1'b0);
    tick();
    chk("R4 on at t+4", 1'b1);
  endtask

  task automatic t_aerr();
    addr_err_chk_en = 1'b1;
    aerr_pulse();
    chk("R5 off after error edge k", 1'b0);
    tick(); tick();
    chk("R6 off at k+2 with req held R10", 1'b0);
    tick();
    chk("R6 off at k+3", 1'b0);
    tick();
    chk("R6 on at k+4", 1'b1);
    aerr_pulse();
    tick();
    aerr_pulse();
    chk("R6 off at restart edge", 1'b0);
    tick(); tick(); tick();
    chk("R6 restarted window still off", 1'b0);
    tick();
    chk("R6 on after restarted window", 1'b1);
  endtask

  task automatic t_aerr_disabled();
    addr_err_chk_en = 1'b0;
    aerr_pulse();
    chk("R7 ignored error edge", 1'b1);
    tick();
    chk("R7 ignored next", 1'b1);
    tick();
    chk("R7 ignored later", 1'b1);
    addr_err_chk_en = 1'b1;
  endtask

  task automatic t_lock();
    local_req = 1'b0;
    lock_2nd_issued = 1'b1;
    tick();
    lock_2nd_issued = 1'b0;
    chk("R2 off with req low", 1'b0);
    aerr_pulse();
    chk("R9 off at k", 1'b0);
    tick();
    chk("R9 off at k+1", 1'b0);
    tick();
    chk("R9 forced on at k+2", 1'b1);
    tick();
    chk("R9 follows req after force", 1'b0);
    local_req = 1'b1;
    lock_2nd_issued = 1'b1;
    lock_done = 1'b1;
    tick();
    lock_2nd_issued = 1'b0;
    lock_done = 1'b0;
    aerr_pulse();
    tick(); tick();
    chk("R8 done wins, no fast reassert", 1'b0);
    tick();
    tick();
    chk("R8 normal window ends at k+4", 1'b1);
  endtask

  task automatic t_binit_clears_lock();
    lock_2nd_issued = 1'b1;
    tick();
    lock_2nd_issued = 1'b0;
    bus_init_n = 1'b0;
    tick();
    bus_init_n = 1'b1;
    repeat (5) tick();
    chk("R4 on after init window", 1'b1);
    aerr_pulse();
    tick(); tick();
    chk("R8 init cleared lock flag", 1'b0);
    tick(); tick();
    chk("R8 on after normal window", 1'b1);
  endtask

  task automatic t_prio();
    lock_2nd_issued = 1'b1;
    tick();
    lock_2nd_issued = 1'b0;
    bus_init_n = 1'b0;
    addr_err_n = 1'b0;
    tick();
    bus_init_n = 1'b1;
    addr_err_n = 1'b1;
    chk("R10 off on combined event", 1'b0);
    tick();
    addr_err_n = 1'b0;
    tick();
    addr_err_n = 1'b1;
    chk("R10 error ignored in init recovery", 1'b0);
    tick(); tick();
    chk("R10 off at t+3", 1'b0);
    tick();
    chk("R10 on at t+4", 1'b1);
  endtask

  task automatic t_reset_lock();
    lock_2nd_issued = 1'b1;
    tick();
    lock_2nd_issued = 1'b0;
    rst_n = 1'b0;
    tick();
    chk("R1 off in reset", 1'b0);
    rst_n = 1'b1;
    tick();
    chk("R2 back after reset", 1'b1);
    aerr_pulse();
    tick(); tick();
    chk("R1 reset cleared lock flag", 1'b0);
  endtask

  initial begin
    rst_n = 1'b0; bus_init_n = 1'b1; addr_err_n = 1'b1; addr_err_chk_en = 1'b0;
    local_req = 1'b0; lock_2nd_issued = 1'b0; lock_done = 1'b0;
    @(negedge clk);
    tick(); tick();
    t_reset_follow();
    t_binit();
    t_aerr();
    t_aerr_disabled();
    t_lock();
    t_binit_clears_lock();
    t_prio();
    t_reset_lock();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #800000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run hung, actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule